// File: doc/BRIEF.md
# Structure Memory Request Unit

This block is one bank of structure memory. It takes request packets of two 16-bit flits from a valid/ready/more link. The first flit carries the request marker, the bank number, an opcode and a cell address. The second flit carries either write data or a routing template supplied by the requester. Some operations produce a result. For those, the block sends back a two-flit packet: the requester's template goes out unchanged as the first flit, and the result data follows as the second. The requester therefore decides where the answer goes, and the bank never builds a destination of its own.

A tier boundary parameter splits the cell array into two parts. Cells below the boundary are plain storage with no presence tracking. Cells at or above it follow I-structure rules. Each such cell is either empty or full. A read of an empty cell is parked, together with its template, until a write fills the cell, and the write then releases the answer. The block also handles a raw read that ignores presence, a clear, and atomic read-increment and read-decrement. Protocol misuse on I-structure cells raises a sticky error flag.

Top module: `smru_top`

## Requirements
- R1: A packet is acted on only when flit 1 has bit 15 = 1 and bits [14:13] equal the BANK_ID parameter. Any other packet is consumed and has no effect on the cells or the outputs.
- R2: When flit 1 bits [12:11] are not 11, bits [12:10] hold a short opcode and bits [9:0] hold the address (000 = read, 001 = write). When they are 11, bits [12:8] hold an extended opcode and bits [7:0] hold the address (11000 = read-increment, 11001 = read-decrement, 11011 = raw read, 11100 = clear). Every other code is consumed with no effect.
- R3: A reply is two flits. The first flit is the request's flit 2 (the template) with out_more = 1. The second flit is the data with out_more = 0. While out_ready is low, out_valid, out_data and out_more hold steady.
- R4: Cells with an address below IS_BASE are raw. A write always stores its data there, and a read replies at once with the stored value.
- R5: A read of a full I-structure cell (address at or above IS_BASE) replies at once. A read of an empty one produces no reply and is held as a pending reader.
- R6: A write to an empty I-structure cell stores the data and marks the cell full. If a reader is pending on that cell, the write also emits a reply built from the held template and the new data.
- R7: A write to a full I-structure cell leaves the data unchanged. A second read held on a cell that already has a pending reader is dropped. Either event sets err_flag, which stays set until reset.
- R8: Read-increment and read-decrement reply with the old value and store the old value plus or minus one, wrapping modulo 2^16, in the same step.
- R9: Raw read replies at once with the stored data in either tier, regardless of presence.
- R10: Clear sets the cell data to zero, marks the cell empty and discards any pending reader.
- R11: After reset, err_flag = 0, out_valid = 0, in_ready = 1, and every I-structure cell is empty with no pending reader.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Incoming request flit |
| in_valid | input | 1 | Incoming flit present |
| in_more | input | 1 | Further flits follow in this packet |
| in_ready | output | 1 | Bank can accept an incoming flit |
| out_data | output | 16 | Reply flit |
| out_valid | output | 1 | Reply flit present |
| out_more | output | 1 | High on the first reply flit only |
| out_ready | input | 1 | Receiver accepts the reply flit |
| err_flag | output | 1 | Sticky protocol-misuse flag |

## Verification
The bench builds the bank with BANK_ID = 1 and IS_BASE = 128. With these values the extended operations, which carry only an 8-bit address, can reach both the raw tier (cells 0 to 127) and the I-structure tier (cells 128 to 255). Short-form requests reach I-structure cells up to 1023. This lets clear and raw read be checked on presence-tracked cells. Using bank 2 and a bit-15-clear flit exercises the foreign-packet drop against a live bank.

// File: rtl/smru_pkg.sv
package smru_pkg;

    localparam int FLIT_W  = 16;
    localparam int ADDR_W  = 10;
    localparam int XADDR_W = 8;

    localparam logic [2:0] SOP_READ  = 3'b000;
    localparam logic [2:0] SOP_WRITE = 3'b001;
    localparam logic [4:0] XOP_RDINC = 5'b11000;
    localparam logic [4:0] XOP_RDDEC = 5'b11001;
    localparam logic [4:0] XOP_RAWRD = 5'b11011;
    localparam logic [4:0] XOP_CLEAR = 5'b11100;

    typedef enum logic [2:0] {
        K_NOP, K_READ, K_WRITE, K_RAWRD, K_CLEAR, K_RDINC, K_RDDEC
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [ADDR_W-1:0] addr;
    } op_dec_t;

    typedef struct packed {
        logic [FLIT_W-1:0] head;
        logic [FLIT_W-1:0] body;
    } req_t;

    typedef struct packed {
        logic              we_data;
        logic [FLIT_W-1:0] wdata;
        logic              we_full;
        logic              full_v;
        logic              we_pend;
        logic              pend_v;
        logic [FLIT_W-1:0] tmpl;
    } cell_cmd_t;

    function automatic op_dec_t smru_decode(logic [FLIT_W-1:0] f1, logic [1:0] id);
        op_dec_t d;
        d.kind = K_NOP;
        d.addr = '0;
        if (f1[15] && (f1[14:13] == id)) begin
            if (f1[12:11] != 2'b11) begin
                d.addr = f1[ADDR_W-1:0];
                case (f1[12:10])
                    SOP_READ:  d.kind = K_READ;
                    SOP_WRITE: d.kind = K_WRITE;
                    default:   d.kind = K_NOP;
                endcase
            end else begin
                d.addr = {{(ADDR_W-XADDR_W){1'b0}}, f1[XADDR_W-1:0]};
                case (f1[12:8])
                    XOP_RDINC: d.kind = K_RDINC;
                    XOP_RDDEC: d.kind = K_RDDEC;
                    XOP_RAWRD: d.kind = K_RAWRD;
                    XOP_CLEAR: d.kind = K_CLEAR;
                    default:   d.kind = K_NOP;
                endcase
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/smru_rx_framer.sv
module smru_rx_framer
    import smru_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLIT_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_more,
    output logic              in_ready,
    output logic              req_valid,
    output req_t              req,
    input  logic              req_take
);

    typedef enum logic [1:0] {RX_HEAD, RX_BODY, RX_SKIP, RX_HOLD} rx_state_e;
    rx_state_e state;
    logic      acc;

    assign in_ready  = (state != RX_HOLD);
    assign req_valid = (state == RX_HOLD);
    assign acc       = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_HEAD;
            req   <= '0;
        end else begin
            case (state)
                RX_HEAD: if (acc) begin
                    req.head <= in_data;
                    // a lone single-flit packet carries no request: drop it
                    state    <= in_more ? RX_BODY : RX_HEAD;
                end
                RX_BODY: if (acc) begin
                    req.body <= in_data;
                    state    <= in_more ? RX_SKIP : RX_HOLD;
                end
                RX_SKIP: if (acc && !in_more) state <= RX_HOLD;
                RX_HOLD: if (req_take) state <= RX_HEAD;
                default: state <= RX_HEAD;
            endcase
        end
    end

    // R1: a framed request stays put until the core takes it
    a_r1_req_hold: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_take |=> req_valid && $stable(req));

endmodule

// File: rtl/smru_cell_store.sv
module smru_cell_store
    import smru_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = FLIT_W,
    localparam int CELLS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  cell_cmd_t     cmd,
    output logic [DW-1:0] rd_data,
    output logic          rd_full,
    output logic          rd_pend,
    output logic [DW-1:0] rd_tmpl
);

    logic [DW-1:0] data_mem [CELLS];
    logic [DW-1:0] tmpl_mem [CELLS];
    logic [CELLS-1:0] full_bits;
    logic [CELLS-1:0] pend_bits;

    assign rd_data = data_mem[addr];
    assign rd_tmpl = tmpl_mem[addr];
    assign rd_full = full_bits[addr];
    assign rd_pend = pend_bits[addr];

    always_ff @(posedge clk) begin
        if (cmd.we_data) data_mem[addr] <= cmd.wdata;
        if (cmd.we_pend && cmd.pend_v) tmpl_mem[addr] <= cmd.tmpl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_bits <= '0;
            pend_bits <= '0;
        end else begin
            if (cmd.we_full) full_bits[addr] <= cmd.full_v;
            if (cmd.we_pend) pend_bits[addr] <= cmd.pend_v;
        end
    end

    // R6: a cell never holds a waiting reader and data at the same time
    a_r6_pend_excl: assert property (@(posedge clk) disable iff (rst)
        rd_pend |-> !rd_full);

endmodule

// File: rtl/smru_reply_tx.sv
module smru_reply_tx
    import smru_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [FLIT_W-1:0] l_head,
    input  logic [FLIT_W-1:0] l_data,
    output logic              idle,
    output logic [FLIT_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_more,
    input  logic              out_ready
);

    typedef enum logic [1:0] {TX_IDLE, TX_HEAD, TX_DATA} tx_state_e;
    tx_state_e         state;
    logic [FLIT_W-1:0] head_q;
    logic [FLIT_W-1:0] data_q;

    assign idle      = (state == TX_IDLE);
    assign out_valid = (state != TX_IDLE);
    assign out_more  = (state == TX_HEAD);
    assign out_data  = (state == TX_HEAD) ? head_q : data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            head_q <= '0;
            data_q <= '0;
        end else begin
            case (state)
                TX_IDLE: if (launch) begin
                    head_q <= l_head;
                    data_q <= l_data;
                    state  <= TX_HEAD;
                end
                TX_HEAD: if (out_ready) state <= TX_DATA;
                TX_DATA: if (out_ready) state <= TX_IDLE;
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R3: a stalled flit does not move
    a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_more));

    // R3: the template flit is always followed by the closing data flit
    a_r3_second_flit: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_more && out_ready |=> out_valid && !out_more);

endmodule

// File: rtl/smru_top.sv
module smru_top
    import smru_pkg::*;
#(
    parameter logic [1:0] BANK_ID = 2'd0,
    parameter int unsigned IS_BASE = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLIT_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_more,
    output logic              in_ready,
    output logic [FLIT_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_more,
    input  logic              out_ready,
    output logic              err_flag
);

    localparam logic [ADDR_W-1:0] TIER_EDGE = ADDR_W'(IS_BASE);

    logic              req_valid;
    logic              req_take;
    req_t              req;
    op_dec_t           dec;
    logic              is_raw;
    logic              go;
    logic              tx_idle;
    logic              launch;
    logic [FLIT_W-1:0] l_head;
    logic [FLIT_W-1:0] l_data;
    cell_cmd_t         cmd;
    logic [FLIT_W-1:0] rd_data;
    logic [FLIT_W-1:0] rd_tmpl;
    logic              rd_full;
    logic              rd_pend;
    logic              err_set;

    smru_rx_framer i_rx (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_more(in_more), .in_ready(in_ready),
        .req_valid(req_valid), .req(req), .req_take(req_take)
    );

    smru_cell_store #(.AW(ADDR_W), .DW(FLIT_W)) i_cells (
        .clk(clk), .rst(rst), .addr(dec.addr), .cmd(cmd),
        .rd_data(rd_data), .rd_full(rd_full), .rd_pend(rd_pend), .rd_tmpl(rd_tmpl)
    );

    smru_reply_tx i_tx (
        .clk(clk), .rst(rst),
        .launch(launch), .l_head(l_head), .l_data(l_data), .idle(tx_idle),
        .out_data(out_data), .out_valid(out_valid), .out_more(out_more), .out_ready(out_ready)
    );

    assign dec      = smru_decode(req.head, BANK_ID);
    assign is_raw   = (dec.addr < TIER_EDGE);
    assign go       = req_valid && tx_idle;
    assign req_take = go;

    always_comb begin
        cmd     = '0;
        launch  = 1'b0;
        l_head  = req.body;
        l_data  = rd_data;
        err_set = 1'b0;
        if (go) begin
            case (dec.kind)
                K_READ: begin
                    if (is_raw || rd_full) begin
                        launch = 1'b1;
                    end else if (rd_pend) begin
                        err_set = 1'b1;
                    end else begin
                        cmd.we_pend = 1'b1;
                        cmd.pend_v  = 1'b1;
                        cmd.tmpl    = req.body;
                    end
                end
                K_WRITE: begin
                    if (is_raw) begin
                        cmd.we_data = 1'b1;
                        cmd.wdata   = req.body;
                    end else if (rd_full) begin
                        err_set = 1'b1;
                    end else begin
                        cmd.we_data = 1'b1;
                        cmd.wdata   = req.body;
                        cmd.we_full = 1'b1;
                        cmd.full_v  = 1'b1;
                        if (rd_pend) begin
                            cmd.we_pend = 1'b1;
                            cmd.pend_v  = 1'b0;
                            launch      = 1'b1;
                            l_head      = rd_tmpl;
                            l_data      = req.body;
                        end
                    end
                end
                K_RAWRD: launch = 1'b1;
                K_CLEAR: begin
                    cmd.we_data = 1'b1;
                    cmd.wdata   = '0;
                    cmd.we_full = 1'b1;
                    cmd.full_v  = 1'b0;
                    cmd.we_pend = 1'b1;
                    cmd.pend_v  = 1'b0;
                end
                K_RDINC: begin
                    launch      = 1'b1;
                    cmd.we_data = 1'b1;
                    cmd.wdata   = rd_data + FLIT_W'(1);
                end
                K_RDDEC: begin
                    launch      = 1'b1;
                    cmd.we_data = 1'b1;
                    cmd.wdata   = rd_data - FLIT_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_flag <= 1'b0;
        else if (err_set) err_flag <= 1'b1;
    end

    // R7: the error flag never drops without reset
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R1: no reply starts while no request is being taken
    a_r1_reply_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(req_valid));

endmodule

// File: tb/test_smru_top.sv
`timescale 1ns/1ps
module test_smru_top;

    localparam logic [1:0] BID = 2'd1;
    localparam int ISB = 128;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] in_data;
    logic        in_valid;
    logic        in_more;
    logic        in_ready;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_more;
    logic        out_ready;
    logic        err_flag;

    int checks = 0;
    int fails  = 0;
    logic [16:0] rx_q [$];

    always #10 clk = ~clk;

    smru_top #(.BANK_ID(BID), .IS_BASE(ISB)) i_smru_top (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_more(in_more),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid), .out_more(out_more),
        .out_ready(out_ready), .err_flag(err_flag)
    );

    always @(negedge clk) if (out_valid && out_ready) rx_q.push_back({out_more, out_data});

    typedef struct packed {
        logic        ext;
        logic [4:0]  op;
        logic [9:0]  addr;
        logic [15:0] f2;
        logic        rep;
        logic [15:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'b00001, 10'd10,  16'h1234, 1'b0, 16'h0000, 4'd4},
        '{1'b0, 5'b00000, 10'd10,  16'h0A01, 1'b1, 16'h1234, 4'd4},
        '{1'b1, 5'b11000, 10'd10,  16'h0A02, 1'b1, 16'h1234, 4'd8},
        '{1'b0, 5'b00000, 10'd10,  16'h0A03, 1'b1, 16'h1235, 4'd8},
        '{1'b1, 5'b11001, 10'd10,  16'h0A04, 1'b1, 16'h1235, 4'd8},
        '{1'b1, 5'b11001, 10'd10,  16'h0A05, 1'b1, 16'h1234, 4'd8},
        '{1'b1, 5'b11011, 10'd10,  16'h0A06, 1'b1, 16'h1233, 4'd9},
        '{1'b0, 5'b00001, 10'd700, 16'hBEEF, 1'b0, 16'h0000, 4'd6},
        '{1'b0, 5'b00000, 10'd700, 16'h0B01, 1'b1, 16'hBEEF, 4'd5},
        '{1'b0, 5'b00001, 10'd5,   16'hFFFF, 1'b0, 16'h0000, 4'd4},
        '{1'b1, 5'b11000, 10'd5,   16'h0B02, 1'b1, 16'hFFFF, 4'd8},
        '{1'b1, 5'b11011, 10'd5,   16'h0B03, 1'b1, 16'h0000, 4'd8},
        '{1'b1, 5'b11001, 10'd5,   16'h0B04, 1'b1, 16'h0000, 4'd8},
        '{1'b1, 5'b11011, 10'd5,   16'h0B05, 1'b1, 16'hFFFF, 4'd8},
        '{1'b1, 5'b11100, 10'd10,  16'h0000, 1'b0, 16'h0000, 4'd10},
        '{1'b0, 5'b00000, 10'd10,  16'h0B06, 1'b1, 16'h0000, 4'd10}
    };

    function automatic logic [15:0] f1s(logic [1:0] id, logic [2:0] op, logic [9:0] a);
        return {1'b1, id, op, a};
    endfunction

    function automatic logic [15:0] f1x(logic [1:0] id, logic [4:0] op, logic [7:0] a);
        return {1'b1, id, op, a};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_flit(input logic [15:0] d, input logic m);
        in_data  = d;
        in_valid = 1'b1;
        in_more  = m;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_pkt(input logic [15:0] h, input logic [15:0] b);
        send_flit(h, 1'b1);
        send_flit(b, 1'b0);
    endtask

    task automatic expect_reply(input logic [15:0] t, input logic [15:0] d, input string req);
        int waited = 0;
        logic [16:0] a, b;
        while (rx_q.size() < 2 && waited < 60) begin
            @(posedge clk);
            waited++;
        end
        #1;
        if (rx_q.size() < 2) begin
            check(1'b0, req, 32'(rx_q.size()), 32'd2);
        end else begin
            a = rx_q.pop_front();
            b = rx_q.pop_front();
            check(a == {1'b1, t} && b == {1'b0, d}, req, {a[15:0], b[15:0]}, {t, d});
        end
    endtask

    task automatic expect_none(input string req);
        repeat (12) @(posedge clk);
        #1;
        check(rx_q.size() == 0, req, 32'(rx_q.size()), 32'd0);
        rx_q.delete();
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        rx_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_data = '0;
        in_valid = 1'b0;
        in_more = 1'b0;
        out_ready = 1'b1;
        do_reset();

        // R11: reset state
        @(negedge clk);
        check(!out_valid && !err_flag && in_ready, "R11 reset outputs",
              {29'd0, out_valid, err_flag, in_ready}, 32'd1);
        @(posedge clk);
        #1;

        // table sweep: R2 R4 R5 R6 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            string tag;
            logic [15:0] h;
            tag = $sformatf("R%0d R2 vec%0d", VEC[i].rq, i);
            h = VEC[i].ext ? f1x(BID, VEC[i].op, VEC[i].addr[7:0])
                           : f1s(BID, VEC[i].op[2:0], VEC[i].addr);
            send_pkt(h, VEC[i].f2);
            if (VEC[i].rep) expect_reply(VEC[i].f2, VEC[i].exp, tag);
            else expect_none(tag);
        end

        // R5 R6: deferred read released by a write
        send_pkt(f1s(BID, 3'b000, 10'd300), 16'h0C01);
        expect_none("R5 deferred read silent");
        send_pkt(f1s(BID, 3'b001, 10'd300), 16'h5555);
        expect_reply(16'h0C01, 16'h5555, "R6 write releases reader");
        send_pkt(f1s(BID, 3'b000, 10'd300), 16'h0C02);
        expect_reply(16'h0C02, 16'h5555, "R5 read of full cell");
        check(!err_flag, "R7 no error yet", {31'd0, err_flag}, 32'd0);

        // R7: write to full cell ignored, error set
        send_pkt(f1s(BID, 3'b001, 10'd300), 16'h9999);
        expect_none("R7 rejected write silent");
        check(err_flag, "R7 err after double write", {31'd0, err_flag}, 32'd1);
        send_pkt(f1s(BID, 3'b000, 10'd300), 16'h0C03);
        expect_reply(16'h0C03, 16'h5555, "R7 data kept");

        // R7: second deferred reader dropped
        do_reset();
        check(!err_flag, "R11 err cleared", {31'd0, err_flag}, 32'd0);
        send_pkt(f1s(BID, 3'b000, 10'd200), 16'h0D01);
        send_pkt(f1s(BID, 3'b000, 10'd200), 16'h0D02);
        expect_none("R7 two held reads silent");
        check(err_flag, "R7 err after second reader", {31'd0, err_flag}, 32'd1);
        send_pkt(f1s(BID, 3'b001, 10'd200), 16'h7777);
        expect_reply(16'h0D01, 16'h7777, "R7 first reader served");
        expect_none("R7 second reader dropped");

        // R10 R9: clear on an I-structure cell
        do_reset();
        send_pkt(f1s(BID, 3'b001, 10'd150), 16'h1111);
        send_pkt(f1x(BID, 5'b11100, 8'd150), 16'h0000);
        send_pkt(f1x(BID, 5'b11011, 8'd150), 16'h0E01);
        expect_reply(16'h0E01, 16'h0000, "R9 raw read of cleared cell");
        send_pkt(f1s(BID, 3'b000, 10'd150), 16'h0E02);
        expect_none("R10 cleared cell empty");
        send_pkt(f1x(BID, 5'b11100, 8'd150), 16'h0000);
        send_pkt(f1s(BID, 3'b001, 10'd150), 16'h2222);
        expect_none("R10 pending reader discarded");
        check(!err_flag, "R10 refill after clear no error", {31'd0, err_flag}, 32'd0);

        // R1: foreign bank and non-request flits
        send_pkt(f1s(BID, 3'b001, 10'd20), 16'hAAAA);
        send_pkt(f1s(2'd2, 3'b001, 10'd20), 16'hBBBB);
        send_pkt({1'b0, BID, 3'b001, 10'd20}, 16'hCCCC);
        send_pkt(f1s(2'd2, 3'b000, 10'd20), 16'h0F00);
        expect_none("R1 foreign packets silent");
        send_pkt(f1s(BID, 3'b000, 10'd20), 16'h0F01);
        expect_reply(16'h0F01, 16'hAAAA, "R1 foreign writes ignored");

        // R2: unused opcodes
        send_pkt(f1s(BID, 3'b010, 10'd20), 16'h1234);
        send_pkt(f1x(BID, 5'b11110, 8'd20), 16'h4321);
        expect_none("R2 unused codes silent");
        send_pkt(f1s(BID, 3'b000, 10'd20), 16'h0F02);
        expect_reply(16'h0F02, 16'hAAAA, "R2 unused codes no effect");

        // R3: backpressure
        out_ready = 1'b0;
        send_pkt(f1s(BID, 3'b000, 10'd20), 16'h0F03);
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(out_valid && out_more && out_data == 16'h0F03, "R3 stalled head held",
              {15'd0, out_valid, out_data}, {15'd0, 1'b1, 16'h0F03});
        @(posedge clk);
        #1;
        out_ready = 1'b1;
        expect_reply(16'h0F03, 16'hAAAA, "R3 reply after stall");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule